// File: doc/BRIEF.md
# Fixed-Off-Time Chopper Controller

This block is the digital control core for one winding of a stepper motor driven through an H-bridge in current mode. While the bridge is on, the winding current rises. A synchronous trip input rises when the sensed current passes the reference. On a trip the controller turns the bridge off for a programmable number of clock cycles. It then turns the bridge back on by itself, with no other event needed.

Right after every turn-on, a blanking window masks the trip input. This keeps the switching spike from ending the on phase early. While the bridge is off, a decay flag tells the bridge logic how to chop. In slow decay only the upper switch is chopped. In fast decay both sides are chopped. In mixed decay both sides are chopped for a programmable first part of the off time and only the upper switch for the rest. A disable input forces everything off and parks the controller, so the next on phase starts fresh with blanking.

Top module: `chopper_ctl`

## Requirements
- R1: After reset, `drive_on` is 1 and `dual_side` is 0. The controller is in a fresh on phase with blanking active.
- R2: For the first max(`blank_cycles`,1) cycles of every on phase, `trip` has no effect. `drive_on` stays 1 during that window.
- R3: Once blanking is over, a `trip` sampled high at a clock edge makes `drive_on` 0 from that edge on. It stays 0 for exactly max(`off_cycles`,1) cycles and then returns to 1 without any other input.
- R4: If `trip` is still high when blanking ends, the bridge turns off at the very next edge.
- R5: With `slow_decay`=1, `dual_side` is 0 for the whole off time, whatever `mix_decay` is.
- R6: With `slow_decay`=0 and `mix_decay`=0, `dual_side` is 1 for the whole off time.
- R7: With `slow_decay`=0 and `mix_decay`=1, `dual_side` is 1 for the first min(`fast_cycles`, max(`off_cycles`,1)) cycles of the off time and 0 for the rest.
- R8: While `bridge_off`=1, both `drive_on` and `dual_side` are 0. After `bridge_off` falls, a new on phase begins with a full blanking window.
- R9: A count of zero in `blank_cycles` or `off_cycles` acts as one cycle.
- R10: `dual_side` is 0 whenever the bridge is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bridge_off | input | 1 | 1 forces both outputs to 0 and holds the controller idle |
| slow_decay | input | 1 | 1 selects upper-side-only chopping during the off time |
| mix_decay | input | 1 | With `slow_decay`=0, selects mixed decay |
| trip | input | 1 | Synchronous current trip from the comparator |
| blank_cycles | input | CNT_W | Blanking window length in cycles |
| off_cycles | input | CNT_W | Off time in cycles |
| fast_cycles | input | CNT_W | Fast part of the off time in mixed decay |
| drive_on | output | 1 | 1 while the bridge conducts |
| dual_side | output | 1 | 1 while both sides chop (off time only) |

## Verification
Two events can meet in one cycle.

The first pair is the end of blanking and a trip that is already high. The bench holds `trip` high across the whole blanking window. It then expects `drive_on` to stay 1 for exactly the blank length and to fall at the next edge.

The second pair is the last fast-decay cycle of the off time and the return to slow chopping or to turn-on. Mixed-decay runs with `fast_cycles` equal to, above and below the off time show where the transition falls. A reference model in the bench judges every cycle, through both directed runs and seeded random runs.

// File: rtl/chop_pkg.sv
package chop_pkg;
   typedef enum logic [1:0] {
      PH_BLANK = 2'd0,
      PH_SENSE = 2'd1,
      PH_OFF   = 2'd2
   } chop_phase_t;
endpackage

// File: rtl/chop_timer.sv
module chop_timer #(
   parameter int W = 14
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic [W-1:0] limit,
   output logic [W-1:0] count,
   output logic         done
);
   localparam int WX = W + 1;

   logic [WX-1:0] nxt_x;

   assign nxt_x = {1'b0, count} + WX'(1);
   // a zero limit behaves as a one-cycle interval
   assign done  = nxt_x >= {1'b0, limit};

   always_ff @(posedge clk) begin
      if (!rst_n || clr) count <= '0;
      else               count <= nxt_x[W-1:0];
   end

   a_r9_single_cycle_min: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && count == '0) |=> (count == W'(1)));
endmodule

// File: rtl/chop_decay.sv
module chop_decay #(
   parameter int W         = 14,
   parameter bit MIX_AVAIL = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_off,
   input  logic         slow_sel,
   input  logic         mix_sel,
   input  logic [W-1:0] off_count,
   input  logic [W-1:0] off_len,
   input  logic [W-1:0] fast_len,
   output logic         dual
);
   logic [W-1:0] off_eff;
   logic [W-1:0] fast_lim;
   logic         fast_part;

   assign off_eff  = (off_len == '0) ? W'(1) : off_len;
   assign fast_lim = (fast_len > off_eff) ? off_eff : fast_len;

   generate
      if (MIX_AVAIL) begin : g_mix
         assign fast_part = !mix_sel || (off_count < fast_lim);
         a_r7_tail_upper_only: assert property (@(posedge clk) disable iff (!rst_n)
            (in_off && !slow_sel && mix_sel && off_count >= fast_len) |-> !dual);
      end else begin : g_nomix
         assign fast_part = 1'b1;
      end
   endgenerate

   assign dual = in_off && !slow_sel && fast_part;

   a_r5_slow_upper_only: assert property (@(posedge clk) disable iff (!rst_n)
      slow_sel |-> !dual);
   a_r6_fast_both_sides: assert property (@(posedge clk) disable iff (!rst_n)
      (in_off && !slow_sel && !mix_sel) |-> dual);
endmodule

// File: rtl/chopper_ctl.sv
module chopper_ctl
   import chop_pkg::*;
#(
   parameter int CNT_W     = 14,
   parameter bit MIX_AVAIL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bridge_off,
   input  logic             slow_decay,
   input  logic             mix_decay,
   input  logic             trip,
   input  logic [CNT_W-1:0] blank_cycles,
   input  logic [CNT_W-1:0] off_cycles,
   input  logic [CNT_W-1:0] fast_cycles,
   output logic             drive_on,
   output logic             dual_side
);
   generate
      if (CNT_W < 2 || CNT_W > 24) begin : g_bad_width
         $error("chopper_ctl: CNT_W out of range");
      end
   endgenerate

   chop_phase_t      ph_q, ph_d;
   logic [CNT_W-1:0] lim;
   logic [CNT_W-1:0] cnt;
   logic             tdone;
   logic             tclr;
   logic             dual_raw;

   always_comb begin
      lim  = (ph_q == PH_OFF) ? off_cycles : blank_cycles;
      ph_d = ph_q;
      unique case (ph_q)
         PH_BLANK: if (tdone) ph_d = PH_SENSE;
         PH_SENSE: if (trip)  ph_d = PH_OFF;
         PH_OFF:   if (tdone) ph_d = PH_BLANK;
         default:             ph_d = PH_BLANK;
      endcase
      if (bridge_off) ph_d = PH_BLANK;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ph_q <= PH_BLANK;
      else        ph_q <= ph_d;
   end

   assign tclr = bridge_off || (ph_d != ph_q) || (ph_q == PH_SENSE);

   chop_timer #(.W(CNT_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tclr),
      .limit (lim),
      .count (cnt),
      .done  (tdone)
   );

   chop_decay #(.W(CNT_W), .MIX_AVAIL(MIX_AVAIL)) u_decay (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_off    (ph_q == PH_OFF),
      .slow_sel  (slow_decay),
      .mix_sel   (mix_decay),
      .off_count (cnt),
      .off_len   (off_cycles),
      .fast_len  (fast_cycles),
      .dual      (dual_raw)
   );

   assign drive_on  = (ph_q != PH_OFF) && !bridge_off;
   assign dual_side = dual_raw && !bridge_off;

   a_r2_blank_keeps_on: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_BLANK && !bridge_off) |=> (drive_on || bridge_off));
   a_r3_trip_turns_off: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_SENSE && trip && !bridge_off) |=> !drive_on);
   a_r8_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
      bridge_off |-> (!drive_on && !dual_side));
   a_r8_fresh_blank: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bridge_off) |-> (ph_q == PH_BLANK));
   a_r10_on_single: assert property (@(posedge clk) disable iff (!rst_n)
      drive_on |-> !dual_side);
endmodule

// File: tb/sim_chopper_ctl.sv
`timescale 1ns/1ps
module sim_chopper_ctl;
   localparam int W = 14;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bridge_off = 1'b0, slow_decay = 1'b0, mix_decay = 1'b0, trip = 1'b0;
   logic [W-1:0] blank_cycles = '0, off_cycles = '0, fast_cycles = '0;
   logic drive_on, dual_side;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;
   int m_ph = 0;
   int m_cnt = 0;

   always #5 clk = ~clk;

   chopper_ctl #(.CNT_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .bridge_off(bridge_off), .slow_decay(slow_decay),
      .mix_decay(mix_decay), .trip(trip), .blank_cycles(blank_cycles),
      .off_cycles(off_cycles), .fast_cycles(fast_cycles),
      .drive_on(drive_on), .dual_side(dual_side));

   function automatic int eff(input int v);
      return (v == 0) ? 1 : v;
   endfunction

   function automatic bit exp_drive();
      return (m_ph != 2) && !bridge_off;
   endfunction

   function automatic bit exp_dual();
      int fl;
      fl = (int'(fast_cycles) > eff(int'(off_cycles))) ? eff(int'(off_cycles)) : int'(fast_cycles);
      return (m_ph == 2) && !bridge_off && !slow_decay && (!mix_decay || m_cnt < fl);
   endfunction

   task automatic model_step();
      if (!rst_n || bridge_off) begin m_ph = 0; m_cnt = 0; end
      else case (m_ph)
         0: if (m_cnt + 1 >= eff(int'(blank_cycles))) begin m_ph = 1; m_cnt = 0; end
            else m_cnt++;
         1: if (trip) begin m_ph = 2; m_cnt = 0; end
         default: if (m_cnt + 1 >= eff(int'(off_cycles))) begin m_ph = 0; m_cnt = 0; end
            else m_cnt++;
      endcase
   endtask

   task automatic check(input string tag, input bit act_d, input bit act_u);
      bit ed, eu;
      ed = exp_drive(); eu = exp_dual();
      n_chk++;
      if (act_d !== ed || act_u !== eu) begin
         n_fail++;
         $display("FAIL %s: drive_on/dual_side act=%b%b exp=%b%b", tag, act_d, act_u, ed, eu);
      end
   endtask

   task automatic cycle(input string tag);
      string t;
      @(posedge clk);
      model_step();
      @(negedge clk);
      t = tag;
      if (t == "") begin
         if (bridge_off)    t = "R8";
         else if (m_ph == 2) t = slow_decay ? "R5" : (mix_decay ? "R7" : "R6");
         else if (m_ph == 0) t = "R2";
         else                t = "R3";
      end
      check(t, drive_on, dual_side);
   endtask

   task automatic setup(input int b, input int o, input int f, input bit s, input bit m);
      blank_cycles = W'(b); off_cycles = W'(o); fast_cycles = W'(f);
      slow_decay = s; mix_decay = m;
   endtask

   initial begin
      int seed;
      seed = int'($urandom(32'd1234));
      setup(3, 5, 2, 1'b1, 1'b0);
      trip = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      check("R1", drive_on, dual_side);
      // R4: trip held through blanking of 3 cycles -> off on next edge
      for (int i = 0; i < 12; i++) cycle("R4");
      trip = 1'b0;
      // R6 fast decay
      setup(2, 6, 0, 1'b0, 1'b0);
      for (int i = 0; i < 6; i++) cycle("R10");
      trip = 1'b1; cycle("R3"); trip = 1'b0;
      for (int i = 0; i < 8; i++) cycle("");
      // R7 mixed, fast below, equal, above off time
      for (int k = 0; k < 3; k++) begin
         setup(1, 6, (k == 0) ? 2 : (k == 1 ? 6 : 9), 1'b0, 1'b1);
         for (int i = 0; i < 3; i++) cycle("R10");
         trip = 1'b1; cycle("R3"); trip = 1'b0;
         for (int i = 0; i < 8; i++) cycle("R7");
      end
      // R9 zero counts
      setup(0, 0, 0, 1'b0, 1'b0);
      trip = 1'b1;
      for (int i = 0; i < 8; i++) cycle("R9");
      trip = 1'b0;
      // R8 disable mid off-time then release
      setup(3, 10, 4, 1'b0, 1'b1);
      for (int i = 0; i < 4; i++) cycle("");
      trip = 1'b1; cycle("R3"); cycle("R7"); trip = 1'b0;
      bridge_off = 1'b1; cycle("R8"); cycle("R8");
      bridge_off = 1'b0; trip = 1'b1;
      for (int i = 0; i < 6; i++) cycle("R8");
      trip = 1'b0;
      // constrained random
      for (int i = 0; i < 3000; i++) begin
         if ($urandom_range(0, 19) == 0)
            setup($urandom_range(0, 5), $urandom_range(0, 12), $urandom_range(0, 14),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
         trip       = ($urandom_range(0, 9) < 3);
         bridge_off = ($urandom_range(0, 39) == 0);
         cycle("");
      end
      bridge_off = 1'b0;
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: act=running exp=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule